// File: doc/BRIEF.md
# ADC Sample Packer with Output Byte Reordering

This block collects narrow converter samples, one per clock of the converter's clock, and combines them in pairs into 32-bit words. Each finished word goes into a 16-word dual-clock FIFO. Samples are written on the converter clock and read on the bus clock. When a word leaves the FIFO, the read side rearranges its bytes as configured and presents the word on a valid/ready port for a DMA engine.

The write side is a two-state machine. In `PK_EMPTY`, no low half is held. In `PK_HALF`, the first sample of a pair waits for its partner. The transitions are:
- `PK_EMPTY`→`PK_HALF` on a sample that is not marked last.
- `PK_EMPTY`→`PK_EMPTY` on a sample marked last. The word is flushed with a zero upper half.
- `PK_HALF`→`PK_EMPTY` on any sample. The full word is pushed.

The read side is also a two-state machine. In `RD_IDLE`, no word is presented. In `RD_HOLD`, a word is presented. The transitions are:
- `RD_IDLE`→`RD_HOLD` when the FIFO is not empty (load).
- `RD_HOLD`→`RD_HOLD` on a handshake with more data (reload).
- `RD_HOLD`→`RD_IDLE` on a handshake with the FIFO empty (drain).

The reorder settings are captured only in `RD_IDLE` while the FIFO is empty.

Top module: `sample_packer_top`

## Requirements
- R1: After reset, `out_valid` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `overflow` is 0.
- R2: Each 12-bit sample is zero-extended to 16 bits. Two consecutive samples form the word {second, first}, with the first sample in bits 15:0. With both reorder settings at 0, the word appears unchanged on `out_data`.
- R3: A sample with `smp_last` = 1 in `PK_EMPTY` is pushed at once as a word whose bits 31:16 are zero.
- R4: Words are delivered in the order they were written.
- R5: With `cfg_big_endian` = 1, the packed word {B3,B2,B1,B0} (B0 = bits 7:0) is delivered as {B0,B1,B2,B3}.
- R6: With `cfg_half_swap` = 1, the two 16-bit halves are exchanged. This happens after the byte order step. With both settings at 1, {B3,B2,B1,B0} becomes {B2,B3,B0,B1}.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R8: The FIFO stores 16 words. When it holds 16, `fifo_full` is 1. A word completed while the FIFO is full is dropped and never delivered.
- R9: A dropped word sets `overflow`. The flag stays set until a cycle with `ovf_clr` = 1 clears it.
- R10: Changes to `cfg_big_endian` or `cfg_half_swap` take effect only once the FIFO is empty and no word is presented. Words already queued keep the settings that were in force before.
- R11: With the FIFO empty and no word presented, `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Converter (write) clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Sample value |
| smp_last | input | 1 | Marks the last sample of a sequence |
| ovf_clr | input | 1 | Clears the overflow flag |
| fifo_full | output | 1 | FIFO full (write domain) |
| overflow | output | 1 | Sticky overflow flag (write domain) |
| rd_clk | input | 1 | Bus (read) clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| cfg_big_endian | input | 1 | Select reversed byte order |
| cfg_half_swap | input | 1 | Exchange 16-bit halves |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_valid | output | 1 | A word is presented |
| out_data | output | 32 | Presented, reordered word |
| fifo_empty | output | 1 | FIFO empty (read domain) |

## Verification
The packing path is tried with four patterns:
- Even-length pairs, where distinct high and low nibbles reveal a swapped half.
- An odd single sample, which must show a zero upper half.
- A long ramp, which exposes a lost, duplicated or reordered word.
- A burst that overruns the FIFO, which separates the sixteenth stored word from the dropped seventeenth.

The four reorder combinations are applied to one word with four distinct bytes, so any wrong byte lane is visible. A settings change while words are queued tells apart capture-at-idle from capture-at-read.

// File: rtl/pk_pkg.sv
package pk_pkg;

    localparam int PK_WORD_W = 32;
    localparam int PK_HALF_W = 16;

    typedef enum logic {PK_EMPTY, PK_HALF} pk_state_t;
    typedef enum logic {RD_IDLE, RD_HOLD} rd_state_t;

    // Byte order first, then the optional half-word exchange.
    function automatic logic [PK_WORD_W-1:0] pk_reorder(
        input logic [PK_WORD_W-1:0] w,
        input logic                 big_end,
        input logic                 swap
    );
        logic [PK_WORD_W-1:0] b;
        b = big_end ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        return swap ? {b[15:0], b[31:16]} : b;
    endfunction

endpackage

// File: rtl/pk_packer.sv
module pk_packer
    import pk_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_data,
    input  logic                 in_last,
    output logic                 push,
    output logic [PK_WORD_W-1:0] push_data
);
    localparam int PAD_W = PK_HALF_W - SAMPLE_W;

    pk_state_t             state, state_nx;
    logic [PK_HALF_W-1:0]  lo_q;
    logic [PK_HALF_W-1:0]  ext;

    assign ext = {{PAD_W{1'b0}}, in_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PK_EMPTY;
            lo_q  <= '0;
        end else begin
            state <= state_nx;
            if (in_valid && state == PK_EMPTY) lo_q <= ext;
        end
    end

    always_comb begin
        state_nx  = state;
        push      = 1'b0;
        push_data = '0;
        unique case (state)
            PK_EMPTY: begin
                if (in_valid) begin
                    if (in_last) begin
                        push      = 1'b1;
                        push_data = {{PK_HALF_W{1'b0}}, ext};
                    end else begin
                        state_nx = PK_HALF;
                    end
                end
            end
            PK_HALF: begin
                if (in_valid) begin
                    push      = 1'b1;
                    push_data = {ext, lo_q};
                    state_nx  = PK_EMPTY;
                end
            end
            default: state_nx = PK_EMPTY;
        endcase
    end

endmodule

// File: rtl/pk_async_fifo.sv
module pk_async_fifo
    import pk_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 wr_clk,
    input  logic                 wr_rst_n,
    input  logic                 push,
    input  logic [PK_WORD_W-1:0] push_data,
    input  logic                 ovf_clr,
    output logic                 full,
    output logic                 overflow,
    input  logic                 rd_clk,
    input  logic                 rd_rst_n,
    input  logic                 pop,
    output logic [PK_WORD_W-1:0] rd_data,
    output logic                 empty
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [PK_WORD_W-1:0] mem [DEPTH];

    logic [PTR_W-1:0] wbin, wgray, rbin, rgray;
    logic [PTR_W-1:0] rgray_s1, rgray_s2, wgray_s1, wgray_s2;
    logic             do_wr, do_rd;

    // write domain
    assign full  = (wgray == {~rgray_s2[PTR_W-1:PTR_W-2], rgray_s2[PTR_W-3:0]});
    assign do_wr = push && !full;

    always_ff @(posedge wr_clk) begin
        if (do_wr) mem[wbin[ADDR_W-1:0]] <= push_data;
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            rgray_s1 <= '0;
            rgray_s2 <= '0;
            overflow <= 1'b0;
        end else begin
            rgray_s1 <= rgray;
            rgray_s2 <= rgray_s1;
            if (do_wr) begin
                wbin  <= wbin + 1'b1;
                wgray <= to_gray(wbin + 1'b1);
            end
            if (push && full) overflow <= 1'b1;
            else if (ovf_clr) overflow <= 1'b0;
        end
    end

    // read domain
    assign empty   = (rgray == wgray_s2);
    assign do_rd   = pop && !empty;
    assign rd_data = mem[rbin[ADDR_W-1:0]];

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            wgray_s1 <= '0;
            wgray_s2 <= '0;
        end else begin
            wgray_s1 <= wgray;
            wgray_s2 <= wgray_s1;
            if (do_rd) begin
                rbin  <= rbin + 1'b1;
                rgray <= to_gray(rbin + 1'b1);
            end
        end
    end

endmodule

// File: rtl/pk_read_port.sv
module pk_read_port
    import pk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 empty,
    input  logic [PK_WORD_W-1:0] rd_data,
    output logic                 pop,
    input  logic                 cfg_be,
    input  logic                 cfg_swap,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [PK_WORD_W-1:0] out_data
);
    rd_state_t state, state_nx;
    logic      load;
    logic      be_q, swap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RD_IDLE;
            out_data <= '0;
            be_q     <= 1'b0;
            swap_q   <= 1'b0;
        end else begin
            state <= state_nx;
            if (load) out_data <= pk_reorder(rd_data, be_q, swap_q);
            if (state == RD_IDLE && empty) begin
                be_q   <= cfg_be;
                swap_q <= cfg_swap;
            end
        end
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            RD_IDLE: begin
                if (!empty) begin
                    load     = 1'b1;
                    state_nx = RD_HOLD;
                end
            end
            RD_HOLD: begin
                if (out_ready) begin
                    if (!empty) load = 1'b1;
                    else state_nx = RD_IDLE;
                end
            end
            default: state_nx = RD_IDLE;
        endcase
    end

    assign pop       = load;
    assign out_valid = (state == RD_HOLD);

endmodule

// File: rtl/sample_packer_top.sv
module sample_packer_top
    import pk_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int ADDR_W   = 4
) (
    input  logic                 wr_clk,
    input  logic                 wr_rst_n,
    input  logic                 smp_valid,
    input  logic [SAMPLE_W-1:0]  smp_data,
    input  logic                 smp_last,
    input  logic                 ovf_clr,
    output logic                 fifo_full,
    output logic                 overflow,
    input  logic                 rd_clk,
    input  logic                 rd_rst_n,
    input  logic                 cfg_big_endian,
    input  logic                 cfg_half_swap,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [PK_WORD_W-1:0] out_data,
    output logic                 fifo_empty
);
    logic                 push, pop;
    logic [PK_WORD_W-1:0] push_data, rd_data;

    pk_packer #(.SAMPLE_W(SAMPLE_W)) u_pack (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .in_valid(smp_valid), .in_data(smp_data), .in_last(smp_last),
        .push(push), .push_data(push_data)
    );

    pk_async_fifo #(.ADDR_W(ADDR_W)) u_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n),
        .push(push), .push_data(push_data), .ovf_clr(ovf_clr),
        .full(fifo_full), .overflow(overflow),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .pop(pop), .rd_data(rd_data), .empty(fifo_empty)
    );

    pk_read_port u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n),
        .empty(fifo_empty), .rd_data(rd_data), .pop(pop),
        .cfg_be(cfg_big_endian), .cfg_swap(cfg_half_swap),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
    );

endmodule

// File: rtl/pk_checker.sv
module pk_checker (
    input logic        wr_clk,
    input logic        wr_rst_n,
    input logic        ovf_clr,
    input logic        fifo_full,
    input logic        overflow,
    input logic        rd_clk,
    input logic        rd_rst_n,
    input logic        out_ready,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        fifo_empty
);
    // R7
    hold_stable_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (overflow && !ovf_clr) |=> overflow);

    // R9
    ovf_clear_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $fell(overflow) |-> $past(ovf_clr));

    // R8
    ovf_needs_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(overflow) |-> $past(fifo_full));

    // R11
    idle_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!out_valid && fifo_empty) |=> !out_valid);

endmodule

bind sample_packer_top pk_checker u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .ovf_clr(ovf_clr),
    .fifo_full(fifo_full), .overflow(overflow),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .fifo_empty(fifo_empty)
);

// File: tb/sim_sample_packer_top.sv
module sim_sample_packer_top;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic        smp_valid = 1'b0, smp_last = 1'b0, ovf_clr = 1'b0;
    logic [11:0] smp_data = '0;
    logic        cfg_big_endian = 1'b0, cfg_half_swap = 1'b0, out_ready = 1'b0;
    logic        fifo_full, overflow, out_valid, fifo_empty;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 wr_clk = ~wr_clk;   // 125 MHz
    always #5 rd_clk = ~rd_clk;

    sample_packer_top u0 (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_last(smp_last), .ovf_clr(ovf_clr),
        .fifo_full(fifo_full), .overflow(overflow),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .cfg_big_endian(cfg_big_endian), .cfg_half_swap(cfg_half_swap),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .fifo_empty(fifo_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack2(input logic [11:0] a, input logic [11:0] b);
        return {4'h0, b, 4'h0, a};
    endfunction

    task automatic push_sample(input logic [11:0] d, input logic last);
        @(negedge wr_clk);
        smp_valid = 1'b1; smp_data = d; smp_last = last;
        @(negedge wr_clk);
        smp_valid = 1'b0; smp_last = 1'b0;
    endtask

    task automatic set_cfg(input logic be, input logic sw);
        cfg_big_endian = be; cfg_half_swap = sw;
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic read_word(input string req, input logic [31:0] exp);
        int n = 0;
        @(negedge rd_clk);
        while (!out_valid && n < 200) begin
            @(negedge rd_clk);
            n++;
        end
        check(req, out_data, exp);
        out_ready = 1'b1;
        @(negedge rd_clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 fifo_empty", {31'b0, fifo_empty}, 32'd1);
        check("R1 fifo_full", {31'b0, fifo_full}, 32'd0);
        check("R1 overflow", {31'b0, overflow}, 32'd0);
    endtask

    task automatic t_pack_le;
        set_cfg(1'b0, 1'b0);
        push_sample(12'h123, 1'b0);
        push_sample(12'hABC, 1'b0);
        read_word("R2 pack", 32'h0ABC0123);
    endtask

    task automatic t_odd_flush;
        push_sample(12'h5A5, 1'b1);
        read_word("R3 flush", 32'h000005A5);
    endtask

    task automatic t_reorder;
        set_cfg(1'b1, 1'b0);
        push_sample(12'h123, 1'b0); push_sample(12'hABC, 1'b0);
        read_word("R5 big-endian", 32'h2301BC0A);
        set_cfg(1'b0, 1'b1);
        push_sample(12'h123, 1'b0); push_sample(12'hABC, 1'b0);
        read_word("R6 swap", 32'h01230ABC);
        set_cfg(1'b1, 1'b1);
        push_sample(12'h123, 1'b0); push_sample(12'hABC, 1'b0);
        read_word("R6 both", 32'hBC0A2301);
        set_cfg(1'b0, 1'b0);
    endtask

    task automatic t_hold;
        int n = 0;
        push_sample(12'h0F1, 1'b0); push_sample(12'h0E2, 1'b0);
        while (!out_valid && n < 200) begin
            @(negedge rd_clk);
            n++;
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge rd_clk);
            check("R7 held valid", {31'b0, out_valid}, 32'd1);
            check("R7 held data", out_data, 32'h00E200F1);
        end
        read_word("R7 release", 32'h00E200F1);
    endtask

    task automatic t_cfg_midstream;
        int n = 0;
        push_sample(12'h111, 1'b0); push_sample(12'h222, 1'b0);
        push_sample(12'h333, 1'b0); push_sample(12'h444, 1'b0);
        while (!out_valid && n < 200) begin
            @(negedge rd_clk);
            n++;
        end
        cfg_big_endian = 1'b1; cfg_half_swap = 1'b1;
        read_word("R10 queued word 1", pack2(12'h111, 12'h222));
        read_word("R10 queued word 2", pack2(12'h333, 12'h444));
        repeat (4) @(negedge rd_clk);
        push_sample(12'h123, 1'b0); push_sample(12'hABC, 1'b0);
        read_word("R10 new setting", 32'hBC0A2301);
        set_cfg(1'b0, 1'b0);
    endtask

    task automatic t_overflow;
        for (int k = 0; k < 17; k++) begin
            push_sample(12'(12'h100 + 2 * k), 1'b0);
            push_sample(12'(12'h101 + 2 * k), 1'b0);
        end
        repeat (6) @(negedge wr_clk);
        check("R8 full at 16", {31'b0, fifo_full}, 32'd1);
        check("R9 no overflow yet", {31'b0, overflow}, 32'd0);
        push_sample(12'hFFE, 1'b0); push_sample(12'hFFF, 1'b0);
        @(negedge wr_clk);
        check("R9 overflow set", {31'b0, overflow}, 32'd1);
        for (int k = 0; k < 17; k++)
            read_word("R4 R8 order", pack2(12'(12'h100 + 2 * k), 12'(12'h101 + 2 * k)));
        repeat (6) @(negedge rd_clk);
        check("R8 dropped word absent", {31'b0, out_valid}, 32'd0);
        check("R11 empty after drain", {31'b0, fifo_empty}, 32'd1);
        @(negedge wr_clk);
        check("R9 overflow sticky", {31'b0, overflow}, 32'd1);
        ovf_clr = 1'b1;
        @(negedge wr_clk);
        ovf_clr = 1'b0;
        check("R9 overflow cleared", {31'b0, overflow}, 32'd0);
        check("R8 not full after drain", {31'b0, fifo_full}, 32'd0);
    endtask

    task automatic t_ramp;
        for (int k = 0; k < 6; k++) begin
            push_sample(12'(12'h700 + 3 * k), 1'b0);
            push_sample(12'(12'h9F0 - k), 1'b0);
        end
        for (int k = 0; k < 6; k++)
            read_word("R4 ramp", pack2(12'(12'h700 + 3 * k), 12'(12'h9F0 - k)));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge rd_clk);
        t_reset();
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        t_reset();
        t_pack_le();
        t_odd_flush();
        t_reorder();
        t_hold();
        t_cfg_midstream();
        t_ramp();
        t_overflow();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule